// File: doc/BRIEF.md
# Receive-Enable Delay Code Normalizer

This block holds one receive-enable delay setting as a four-field mixed-radix number. From fine to coarse the fields are a sub-tap count `p`, a tap count `t`, a phase `ph` and a whole-clock count `c`. A training engine steers the delay with signed step commands. The commands are a one-unit fine step, a quarter step in either direction, a half backstep, a full-clock backstep and a signed add to `t`. There are also commands that load `c` and set the preamble offset. After each command the block brings every field back into its canonical range. It does this one carry or one borrow per clock, and pulses `done` when the code is settled.

The radices of `t` and `p` depend on the speed grade and the memory kind. They are latched when a command is accepted. `ph` always moves in steps of two and wraps at four into `c`. The settled code is shown as a packed group word and a packed per-channel word. If `c` settles outside 0..15, a sticky error flag is raised.

Top module: `rxen_delay_norm`

## Requirements
- R1: While reset is active, and after it is released, both words are zero and `busy_o`, `done_o` and `err_o` are low.
- R2: When a command is accepted, the tap bound TB and the sub-tap bound PB are latched. With `fast_grade_i`=1, TB=9 and PB=8. Otherwise `ddr3_i`=1 gives TB=12 and `ddr3_i`=0 gives TB=15, both with PB=1.
- R3: A `p` at or above PB loses PB and gives +1 to `t`. A negative `p` gains PB and takes 1 from `t`.
- R4: A `t` at or above TB loses TB and gives +2 to `ph`. A negative `t` gains TB and takes 2 from `ph`. A settled `t` lies in 0..TB-1.
- R5: A `ph` at or above 4 loses 4 and gives +1 to `c`. A negative `ph` gains 4 and takes 1 from `c`. `ph` is always even.
- R6: A quarter step (op 2) adds TB>>1 to `t` and (TB&1)*(PB>>1) to `p`. A quarter backstep (op 3) subtracts the same two amounts.
- R7: A fine step (op 1) adds 1 to `p`. A half backstep (op 4) subtracts 2 from `ph`. A full backstep (op 5) subtracts 1 from `c`.
- R8: Load (op 0) sets `c` to the sign-extended `cmd_arg_i` and clears `p`, `t` and `ph`. Add (op 6) adds the signed `cmd_arg_i` to `t`. Set-preamble (op 7) stores `cmd_arg_i[1:0]` as the preamble offset.
- R9: An accepted command applies its step at the accepting edge and raises `busy_o`. Each later edge performs one correction, in the priority `p`, then `t`, then `ph`. The edge after the code is in range drops `busy_o` and pulses `done_o` for one cycle. A command that needs N corrections therefore completes N+1 edges after it is accepted.
- R10: `cmd_valid_i` is ignored while `busy_o` is high.
- R11: When a command completes with `c` outside 0..15, `err_o` goes high. It stays high until reset.
- R12: The group word carries `t[3:0]` in bits 31:28, `p[2:0]` in bits 26:24, `ph[1:0]` in bits 23:22 and the preamble in bits 21:20. The channel word carries `c[3:0]` in bits 10:7. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_grade_i | input | 1 | Selects the fastest speed-grade bounds |
| ddr3_i | input | 1 | Selects the DDR3 tap bound at the slower grades |
| cmd_valid_i | input | 1 | Command request, taken while idle |
| cmd_op_i | input | 3 | Command code (R6 to R8) |
| cmd_arg_i | input | 6 | Signed argument for load, add and preamble |
| busy_o | output | 1 | Normalization in progress |
| done_o | output | 1 | One-cycle pulse when the code is settled |
| err_o | output | 1 | Sticky out-of-range flag for `c` |
| group_word_o | output | 32 | Packed per-group timing word |
| chan_word_o | output | 32 | Packed per-channel clock word |

## Verification
For each stimulus the due cycle is worked out by hand. The cycle is the accepting edge plus one edge for every carry or borrow that the step causes, plus one final settling edge. The bench drives commands at falling edges. It counts falling edges after acceptance until `done_o` is seen and compares that count with the expected latency. In the same half cycle it samples both words. It also checks that `busy_o` is high one half cycle after acceptance, and it injects a command during the busy window to confirm that the command is dropped.

// File: rtl/rxen_pkg.sv
package rxen_pkg;

    localparam int P_W     = 5;
    localparam int T_W     = 8;
    localparam int PH_W    = 5;
    localparam int C_W     = 7;
    localparam int ARG_W   = 6;
    localparam int TB_W    = 4;
    localparam int PB_W    = 4;
    localparam int PRE_W   = 2;
    localparam int C_MAX   = 15;
    localparam int PH_MOD  = 4;
    localparam int PH_STEP = 2;

    typedef enum logic [2:0] {
        OP_LOAD_C    = 3'd0,
        OP_FINE      = 3'd1,
        OP_QFWD      = 3'd2,
        OP_QBACK     = 3'd3,
        OP_HALF_BACK = 3'd4,
        OP_FULL_BACK = 3'd5,
        OP_ADD_T     = 3'd6,
        OP_SET_PRE   = 3'd7
    } step_op_e;

    typedef struct packed {
        logic signed [P_W-1:0]  p;
        logic signed [T_W-1:0]  t;
        logic signed [PH_W-1:0] ph;
        logic signed [C_W-1:0]  c;
    } delay_code_t;

    typedef struct packed {
        delay_code_t      code;
        logic [PRE_W-1:0] pre;
        logic [TB_W-1:0]  tb;
        logic [PB_W-1:0]  pb;
        logic             busy;
        logic             done;
        logic             err;
    } norm_state_t;

endpackage

// File: rtl/rxen_bound_sel.sv
module rxen_bound_sel #(
    parameter int TB_W    = 4,
    parameter int PB_W    = 4,
    parameter int TB_FAST = 9,
    parameter int TB_DDR3 = 12,
    parameter int TB_DDR2 = 15,
    parameter int PB_FAST = 8,
    parameter int PB_SLOW = 1
) (
    input  logic            fast_i,
    input  logic            ddr3_i,
    output logic [TB_W-1:0] tb_o,
    output logic [PB_W-1:0] pb_o
);
    always_comb begin
        if (fast_i) begin
            tb_o = TB_W'(TB_FAST);
            pb_o = PB_W'(PB_FAST);
        end else begin
            tb_o = ddr3_i ? TB_W'(TB_DDR3) : TB_W'(TB_DDR2);
            pb_o = PB_W'(PB_SLOW);
        end
    end
endmodule

// File: rtl/rxen_step_unit.sv
module rxen_step_unit
    import rxen_pkg::*;
(
    input  logic [2:0]       op_i,
    input  logic [ARG_W-1:0] arg_i,
    input  logic [TB_W-1:0]  tb_i,
    input  logic [PB_W-1:0]  pb_i,
    input  delay_code_t      code_i,
    input  logic [PRE_W-1:0] pre_i,
    output delay_code_t      code_o,
    output logic [PRE_W-1:0] pre_o
);
    logic [T_W-1:0] qtr_t;
    logic [P_W-1:0] qtr_p;
    step_op_e       op;

    assign op    = step_op_e'(op_i);
    assign qtr_t = {{(T_W-TB_W){1'b0}}, tb_i >> 1};
    assign qtr_p = tb_i[0] ? {{(P_W-PB_W){1'b0}}, pb_i >> 1} : '0;

    always_comb begin
        code_o = code_i;
        pre_o  = pre_i;
        case (op)
            OP_LOAD_C: begin
                code_o   = '0;
                code_o.c = {{(C_W-ARG_W){arg_i[ARG_W-1]}}, arg_i};
            end
            OP_FINE:      code_o.p  = code_i.p + P_W'(1);
            OP_QFWD: begin
                code_o.t = code_i.t + qtr_t;
                code_o.p = code_i.p + qtr_p;
            end
            OP_QBACK: begin
                code_o.t = code_i.t - qtr_t;
                code_o.p = code_i.p - qtr_p;
            end
            OP_HALF_BACK: code_o.ph = code_i.ph - PH_W'(PH_STEP);
            OP_FULL_BACK: code_o.c  = code_i.c - C_W'(1);
            OP_ADD_T:     code_o.t  = code_i.t + {{(T_W-ARG_W){arg_i[ARG_W-1]}}, arg_i};
            OP_SET_PRE:   pre_o     = arg_i[PRE_W-1:0];
            default:      code_o    = code_i;
        endcase
    end
endmodule

// File: rtl/rxen_carry_unit.sv
module rxen_carry_unit
    import rxen_pkg::*;
(
    input  delay_code_t     code_i,
    input  logic [TB_W-1:0] tb_i,
    input  logic [PB_W-1:0] pb_i,
    output delay_code_t     code_o,
    output logic            settled_o
);
    localparam logic signed [PH_W-1:0] PH_LIM = PH_W'(PH_MOD);

    logic signed [T_W-1:0] tb_s;
    logic signed [P_W-1:0] pb_s;

    assign tb_s = {{(T_W-TB_W){1'b0}}, tb_i};
    assign pb_s = {{(P_W-PB_W){1'b0}}, pb_i};

    always_comb begin
        code_o    = code_i;
        settled_o = 1'b0;
        if (code_i.p >= pb_s) begin
            code_o.p = code_i.p - pb_s;
            code_o.t = code_i.t + T_W'(1);
        end else if (code_i.p[P_W-1]) begin
            code_o.p = code_i.p + pb_s;
            code_o.t = code_i.t - T_W'(1);
        end else if (code_i.t >= tb_s) begin
            code_o.t  = code_i.t - tb_s;
            code_o.ph = code_i.ph + PH_W'(PH_STEP);
        end else if (code_i.t[T_W-1]) begin
            code_o.t  = code_i.t + tb_s;
            code_o.ph = code_i.ph - PH_W'(PH_STEP);
        end else if (code_i.ph >= PH_LIM) begin
            code_o.ph = code_i.ph - PH_LIM;
            code_o.c  = code_i.c + C_W'(1);
        end else if (code_i.ph[PH_W-1]) begin
            code_o.ph = code_i.ph + PH_LIM;
            code_o.c  = code_i.c - C_W'(1);
        end else begin
            settled_o = 1'b1;
        end
    end
endmodule

// File: rtl/rxen_word_pack.sv
module rxen_word_pack (
    input  logic [3:0]  t_i,
    input  logic [2:0]  p_i,
    input  logic [1:0]  ph_i,
    input  logic [1:0]  pre_i,
    input  logic [3:0]  c_i,
    output logic [31:0] group_word_o,
    output logic [31:0] chan_word_o
);
    localparam int T_LSB   = 28;
    localparam int P_LSB   = 24;
    localparam int PH_LSB  = 22;
    localparam int PRE_LSB = 20;
    localparam int C_LSB   = 7;

    always_comb begin
        group_word_o = '0;
        group_word_o[T_LSB   +: 4] = t_i;
        group_word_o[P_LSB   +: 3] = p_i;
        group_word_o[PH_LSB  +: 2] = ph_i;
        group_word_o[PRE_LSB +: 2] = pre_i;
        chan_word_o  = '0;
        chan_word_o[C_LSB +: 4]    = c_i;
    end
endmodule

// File: rtl/rxen_delay_norm.sv
module rxen_delay_norm
    import rxen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_grade_i,
    input  logic        ddr3_i,
    input  logic        cmd_valid_i,
    input  logic [2:0]  cmd_op_i,
    input  logic [5:0]  cmd_arg_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [31:0] group_word_o,
    output logic [31:0] chan_word_o
);
    localparam logic signed [C_W-1:0] C_HI = C_W'(C_MAX);

    norm_state_t      s_d, s_q;
    logic [TB_W-1:0]  tb_sel;
    logic [PB_W-1:0]  pb_sel;
    delay_code_t      stepped_code, carried_code;
    logic [PRE_W-1:0] stepped_pre;
    logic             settled;
    logic             c_bad;

    rxen_bound_sel #(.TB_W(TB_W), .PB_W(PB_W)) u_bounds (
        .fast_i (fast_grade_i),
        .ddr3_i (ddr3_i),
        .tb_o   (tb_sel),
        .pb_o   (pb_sel)
    );

    rxen_step_unit u_step (
        .op_i   (cmd_op_i),
        .arg_i  (cmd_arg_i),
        .tb_i   (tb_sel),
        .pb_i   (pb_sel),
        .code_i (s_q.code),
        .pre_i  (s_q.pre),
        .code_o (stepped_code),
        .pre_o  (stepped_pre)
    );

    rxen_carry_unit u_carry (
        .code_i    (s_q.code),
        .tb_i      (s_q.tb),
        .pb_i      (s_q.pb),
        .code_o    (carried_code),
        .settled_o (settled)
    );

    assign c_bad = s_q.code.c[C_W-1] || (s_q.code.c > C_HI);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (cmd_valid_i) begin
                s_d.tb   = tb_sel;
                s_d.pb   = pb_sel;
                s_d.code = stepped_code;
                s_d.pre  = stepped_pre;
                s_d.busy = 1'b1;
            end
        end else if (settled) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            if (c_bad) begin
                s_d.err = 1'b1;
            end
        end else begin
            s_d.code = carried_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rxen_word_pack u_pack (
        .t_i          (s_q.code.t[3:0]),
        .p_i          (s_q.code.p[2:0]),
        .ph_i         (s_q.code.ph[1:0]),
        .pre_i        (s_q.pre),
        .c_i          (s_q.code.c[3:0]),
        .group_word_o (group_word_o),
        .chan_word_o  (chan_word_o)
    );

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign err_o  = s_q.err;
endmodule

// File: rtl/rxen_delay_norm_chk.sv
module rxen_delay_norm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [31:0] group_word_o,
    input logic [31:0] chan_word_o
);
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !busy_o) |=> busy_o);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !cmd_valid_i) |=>
            ($stable(group_word_o) && $stable(chan_word_o) && $stable(err_o)));

    p_ph_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        group_word_o[22] == 1'b0);

    p_t_settled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (group_word_o[31:28] <= 4'd14));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

bind rxen_delay_norm rxen_delay_norm_chk u_chk (.*);

// File: tb/rxen_delay_norm_bench.sv
module rxen_delay_norm_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_grade_i = 1'b1;
    logic        ddr3_i = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [2:0]  cmd_op_i = '0;
    logic [5:0]  cmd_arg_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] group_word_o, chan_word_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxen_delay_norm u_rxen_delay_norm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_grade_i (fast_grade_i),
        .ddr3_i       (ddr3_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (cmd_op_i),
        .cmd_arg_i    (cmd_arg_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .group_word_o (group_word_o),
        .chan_word_o  (chan_word_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one command; lat counts falling edges after acceptance until done.
    // With inject set, a full backstep is offered during the busy window.
    task automatic issue(input logic [2:0] op, input logic [5:0] arg, input int exp_lat,
                         input bit inject, input string tag);
        int lat;
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_arg_i   = arg;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk({tag, " R9 busy after accept"}, 32'(busy_o), 32'd1);
        if (inject) begin
            cmd_valid_i = 1'b1;
            cmd_op_i    = 3'd5;
            cmd_arg_i   = '0;
        end
        lat = 1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " R9 latency"}, 32'(lat), 32'(exp_lat));
        chk({tag, " R9 idle at done"}, 32'(busy_o), 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 group in reset", group_word_o, 32'h0);
        chk("R1 flags in reset", {29'd0, busy_o, done_o, err_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 chan after reset", chan_word_o, 32'h0);
        chk("R1 flags after reset", {29'd0, busy_o, done_o, err_o}, 32'h0);
    endtask

    task automatic t_fast_quarters();
        fast_grade_i = 1'b1;
        issue(3'd0, 6'd5, 1, 1'b0, "R8 load c5");
        chk("R8 load chan", chan_word_o, 32'h0000_0280);
        chk("R8 load group", group_word_o, 32'h0);
        issue(3'd2, 6'd0, 1, 1'b0, "R6 qfwd1");
        chk("R6 R2 fast qfwd t4 p4", group_word_o, 32'h4400_0000);
        issue(3'd2, 6'd0, 3, 1'b0, "R3 qfwd2");
        chk("R3 R4 p carry then t carry", group_word_o, 32'h0080_0000);
        issue(3'd2, 6'd0, 1, 1'b0, "R6 qfwd3");
        issue(3'd2, 6'd0, 4, 1'b0, "R5 qfwd4");
        chk("R5 ph wrap group", group_word_o, 32'h0);
        chk("R5 ph wrap chan", chan_word_o, 32'h0000_0300);
    endtask

    task automatic t_quarter_back();
        issue(3'd3, 6'd0, 4, 1'b0, "R6 qback");
        chk("R6 R3 R4 R5 qback borrows", group_word_o, 32'h4480_0000);
        chk("R5 qback chan", chan_word_o, 32'h0000_0280);
    endtask

    task automatic t_ddr3_steps();
        fast_grade_i = 1'b0;
        ddr3_i = 1'b1;
        issue(3'd0, 6'd3, 1, 1'b0, "R8 load c3");
        issue(3'd2, 6'd0, 1, 1'b0, "R2 ddr3 qfwd");
        chk("R2 R6 ddr3 quarter t6", group_word_o, 32'h6000_0000);
        issue(3'd1, 6'd0, 2, 1'b0, "R7 fine");
        chk("R7 R3 fine carries p into t", group_word_o, 32'h7000_0000);
        issue(3'd4, 6'd0, 2, 1'b0, "R7 half");
        chk("R7 half back group", group_word_o, 32'h7080_0000);
        chk("R7 half back chan", chan_word_o, 32'h0000_0100);
        issue(3'd5, 6'd0, 1, 1'b0, "R7 full");
        chk("R7 full back chan", chan_word_o, 32'h0000_0080);
    endtask

    task automatic t_ddr2_quarters();
        fast_grade_i = 1'b0;
        ddr3_i = 1'b0;
        issue(3'd0, 6'd4, 1, 1'b0, "R8 load c4");
        issue(3'd2, 6'd0, 1, 1'b0, "R2 ddr2 q1");
        issue(3'd2, 6'd0, 1, 1'b0, "R4 ddr2 q2");
        chk("R4 R2 t14 below bound 15", group_word_o, 32'hE000_0000);
        issue(3'd2, 6'd0, 2, 1'b0, "R4 ddr2 q3");
        chk("R4 t carry at 15", group_word_o, 32'h6080_0000);
        chk("R4 chan unchanged", chan_word_o, 32'h0000_0200);
    endtask

    task automatic t_add_t();
        fast_grade_i = 1'b1;
        issue(3'd0, 6'd2, 1, 1'b0, "R8 load c2");
        issue(3'd6, 6'h3F, 3, 1'b0, "R8 add -1");
        chk("R8 add -1 group", group_word_o, 32'h8080_0000);
        chk("R8 add -1 chan", chan_word_o, 32'h0000_0080);
        issue(3'd6, 6'd20, 6, 1'b0, "R8 add 20");
        chk("R8 R4 R5 multi carry group", group_word_o, 32'h1000_0000);
        chk("R8 multi carry chan", chan_word_o, 32'h0000_0180);
    endtask

    task automatic t_pre();
        issue(3'd7, 6'd3, 1, 1'b0, "R8 pre");
        chk("R12 R8 preamble bits", group_word_o, 32'h1030_0000);
    endtask

    task automatic t_busy_ignore();
        issue(3'd6, 6'd20, 4, 1'b1, "R10 inject");
        chk("R10 command while busy dropped group", group_word_o, 32'h3030_0000);
        chk("R10 command while busy dropped chan", chan_word_o, 32'h0000_0200);
    endtask

    task automatic t_error();
        issue(3'd0, 6'd0, 1, 1'b0, "R11 load c0");
        chk("R11 no error at c0", 32'(err_o), 32'd0);
        issue(3'd5, 6'd0, 1, 1'b0, "R11 underflow");
        chk("R11 error on c=-1", 32'(err_o), 32'd1);
        chk("R12 c low bits", chan_word_o, 32'h0000_0780);
        issue(3'd0, 6'd5, 1, 1'b0, "R11 reload");
        chk("R11 error sticky", 32'(err_o), 32'd1);
        do_reset();
        chk("R11 error cleared by reset", 32'(err_o), 32'd0);
        issue(3'd0, 6'd16, 1, 1'b0, "R11 load c16");
        chk("R11 error on c=16", 32'(err_o), 32'd1);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_fast_quarters();
        t_quarter_back();
        t_ddr3_steps();
        t_ddr2_quarters();
        t_add_t();
        t_pre();
        t_busy_ignore();
        t_error();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule